// File: doc/BRIEF.md
# Saturating Integer Dot-Product Accumulator

This unit multiplies two integer vectors lane by lane, adds the products together, and adds that sum to an accumulator operand. Only that last addition saturates. A two-bit mode input sets how the lanes are widened to the result width:

- both vectors signed;
- both vectors unsigned;
- the first vector signed and the second unsigned.

A separate packed flag makes the unit read the low 32 bits of each vector operand as four 8-bit lanes. This holds whatever the configured lane count and lane width are.

The lane count, lane width and result width are parameters. The accumulator has the same width as the result. Operations enter with a valid strobe. Each result leaves exactly two clock cycles later with its own valid strobe. One operation can start on every cycle.

Top module: `dotacc_sat`

## Requirements
- R1: With mode 2'b00, every lane of both vectors is sign-extended to the result width before multiplication.
- R2: With mode 2'b01, lanes of vector A are sign-extended and lanes of vector B are zero-extended.
- R3: With mode 2'b10, lanes of both vectors are zero-extended.
- R4: Mode 2'b11 behaves exactly like mode 2'b00.
- R5: In modes 2'b00, 2'b01 and 2'b11, the accumulator add clamps to the signed range of the result width: the most positive value on overflow, the most negative value on underflow.
- R6: In mode 2'b10, a carry out of the accumulator add forces the result to all ones.
- R7: When the packed flag is set, the low 32 bits of each vector operand hold four 8-bit lanes. Lane 0 is bits [7:0] and lane 3 is bits [31:24]. The configured lane layout is not used.
- R8: `out_valid` is asserted exactly two cycles after `in_valid`, and the matching result is presented in that same cycle.
- R9: While `out_valid` is low, `out_result` keeps its previous value.
- R10: While `rst_n` is low at a clock edge, `out_valid` and `out_result` become zero.
- R11: When every lane of vector A is zero, the result equals the accumulator operand, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 2 | Signedness mode (00 signed, 01 mixed, 10 unsigned, 11 as 00) |
| in_packed | input | 1 | Read operands as four 8-bit lanes in the low 32 bits |
| in_vec_a | input | LANES*LANE_W | Vector A, lane 0 in the low bits |
| in_vec_b | input | LANES*LANE_W | Vector B, lane 0 in the low bits |
| in_acc | input | RES_W | Accumulator operand |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_result | output | RES_W | Saturated accumulation result |

## Verification
The properties and the reference model both assume that the lane products and their reduction fit in the result width. Overflow there is left undefined: the datapath simply wraps it. The stimulus stays inside this assumption by using two 16-bit lanes with a 40-bit result. Even the largest lane values then reduce to well under 2^39, while the accumulator is still swept across both saturation bounds. The latency and hold properties assume only that reset has been released for at least two cycles.

// File: rtl/dotacc_pkg.sv
// Package: shared mode type and decode helpers for the dot-product accumulator.
// Assumes the mode field is two bits; the reserved code decodes as signed.
package dotacc_pkg;

    typedef enum logic [1:0] {
        DM_SS  = 2'b00,
        DM_SU  = 2'b01,
        DM_UU  = 2'b10,
        DM_RSV = 2'b11
    } dot_mode_e;

    // Vector A lanes are sign-extended in every mode except unsigned.
    function automatic logic lane_a_signed(dot_mode_e m);
        return (m != DM_UU);
    endfunction

    // Vector B lanes are sign-extended only in the signed mode or the reserved code.
    function automatic logic lane_b_signed(dot_mode_e m);
        return (m == DM_SS) || (m == DM_RSV);
    endfunction

    // The final add clamps to the signed range unless the mode is unsigned.
    function automatic logic sat_is_signed(dot_mode_e m);
        return (m != DM_UU);
    endfunction

endpackage

// File: rtl/dotacc_lane_mul.sv
// Module: widens one pair of lanes to OUT_W bits and multiplies them.
// Assumes OUT_W >= IN_W. The product is truncated to OUT_W; overflow wraps silently.
module dotacc_lane_mul #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  lane_a,
    input  logic [IN_W-1:0]  lane_b,
    input  logic             a_sext,
    input  logic             b_sext,
    output logic [OUT_W-1:0] prod
);

    logic signed [IN_W-1:0] a_s;
    logic signed [IN_W-1:0] b_s;
    logic [OUT_W-1:0]       a_ext;
    logic [OUT_W-1:0]       b_ext;

    assign a_s = $signed(lane_a);
    assign b_s = $signed(lane_b);

    // Widen each lane by sign or zero extension.
    always_comb begin
        a_ext = a_sext ? OUT_W'(a_s) : OUT_W'(lane_a);
        b_ext = b_sext ? OUT_W'(b_s) : OUT_W'(lane_b);
    end

    // Multiply modulo 2^OUT_W; the low bits are the same for signed and unsigned.
    assign prod = a_ext * b_ext;

endmodule

// File: rtl/dotacc_reduce_sat.sv
// Module: sums NPROD products and adds the accumulator with saturation.
// Purely combinational. The reduction wraps modulo 2^W; only the final add clamps.
module dotacc_reduce_sat #(
    parameter int NPROD = 4,
    parameter int W     = 32
) (
    input  logic [NPROD-1:0][W-1:0] prods,
    input  logic [W-1:0]            acc,
    input  logic                    sat_signed,
    output logic [W-1:0]            result
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

    logic [W-1:0] sum;
    logic [W:0]   ext_s;
    logic [W:0]   ext_u;

    // Wrapping reduction of all lane products.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NPROD; i++) begin
            sum = sum + prods[i];
        end
    end

    // One-bit-wider adds: sign-extended for the signed path, zero-extended for unsigned.
    assign ext_s = {acc[W-1], acc} + {sum[W-1], sum};
    assign ext_u = {1'b0, acc} + {1'b0, sum};

    // Clamp when the two top bits disagree (signed) or on carry out (unsigned).
    always_comb begin
        if (sat_signed) begin
            if (ext_s[W] != ext_s[W-1]) begin
                result = ext_s[W] ? MIN_NEG : MAX_POS;
            end else begin
                result = ext_s[W-1:0];
            end
        end else begin
            result = ext_u[W] ? ALL_ONE : ext_u[W-1:0];
        end
    end

endmodule

// File: rtl/dotacc_sat.sv
// Module: two-stage saturating integer dot-product accumulator (top).
// Stage 1 registers the widened lane products and stage 2 registers the saturated sum.
// Assumes RES_W >= LANE_W, RES_W >= 8, and that the products and their sum fit in RES_W bits.
module dotacc_sat
    import dotacc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int RES_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_mode,
    input  logic                    in_packed,
    input  logic [LANES*LANE_W-1:0] in_vec_a,
    input  logic [LANES*LANE_W-1:0] in_vec_b,
    input  logic [RES_W-1:0]        in_acc,
    output logic                    out_valid,
    output logic [RES_W-1:0]        out_result
);

    localparam int OPW      = LANES * LANE_W;
    localparam int PK_LANES = 4;
    localparam int PK_W     = 8;
    localparam int PL       = (LANES > PK_LANES) ? LANES : PK_LANES;
    localparam int PADW     = (OPW > 32) ? OPW : 32;

    dot_mode_e mode_d;
    logic      a_sx;
    logic      b_sx;
    logic      sat_sg;

    logic [PADW-1:0] a_pad;
    logic [PADW-1:0] b_pad;

    logic [PL-1:0][RES_W-1:0] nat_p;
    logic [PL-1:0][RES_W-1:0] pk_p;
    logic [PL-1:0][RES_W-1:0] sel_p;

    logic                     s1_valid;
    logic [PL-1:0][RES_W-1:0] s1_prod;
    logic [RES_W-1:0]         s1_acc;
    logic                     s1_sgn;
    logic [RES_W-1:0]         s2_d;

    // Decode the mode into per-vector extension controls.
    assign mode_d = dot_mode_e'(in_mode);
    assign a_sx   = lane_a_signed(mode_d);
    assign b_sx   = lane_b_signed(mode_d);
    assign sat_sg = sat_is_signed(mode_d);

    // Zero-pad the operands so that the packed view always has 32 bits available.
    assign a_pad = PADW'(in_vec_a);
    assign b_pad = PADW'(in_vec_b);

    // One native multiplier and one packed multiplier per product slot, as the configuration allows.
    for (genvar g = 0; g < PL; g++) begin : g_lane
        if (g < LANES) begin : g_nat
            dotacc_lane_mul #(.IN_W(LANE_W), .OUT_W(RES_W)) u_nat (
                .lane_a (in_vec_a[g*LANE_W +: LANE_W]),
                .lane_b (in_vec_b[g*LANE_W +: LANE_W]),
                .a_sext (a_sx),
                .b_sext (b_sx),
                .prod   (nat_p[g])
            );
        end else begin : g_nat_off
            assign nat_p[g] = '0;
        end
        if (g < PK_LANES) begin : g_pk
            dotacc_lane_mul #(.IN_W(PK_W), .OUT_W(RES_W)) u_pk (
                .lane_a (a_pad[g*PK_W +: PK_W]),
                .lane_b (b_pad[g*PK_W +: PK_W]),
                .a_sext (a_sx),
                .b_sext (b_sx),
                .prod   (pk_p[g])
            );
        end else begin : g_pk_off
            assign pk_p[g] = '0;
        end
    end

    // Choose the packed or the native product set.
    assign sel_p = in_packed ? pk_p : nat_p;

    // Stage 1: register the products, the accumulator and the saturation kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_prod  <= '0;
            s1_acc   <= '0;
            s1_sgn   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_prod <= sel_p;
                s1_acc  <= in_acc;
                s1_sgn  <= sat_sg;
            end
        end
    end

    dotacc_reduce_sat #(.NPROD(PL), .W(RES_W)) u_red (
        .prods      (s1_prod),
        .acc        (s1_acc),
        .sat_signed (s1_sgn),
        .result     (s2_d)
    );

    // Stage 2: register the saturated result; hold it while no operation completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_result <= s2_d;
            end
        end
    end

endmodule

// File: rtl/dotacc_sat_chk.sv
// Checker: timing and pass-through properties of dotacc_sat, attached with bind.
// Assumes reset has been released for two cycles before any history-based check applies.
module dotacc_sat_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int RES_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [1:0]              in_mode,
    input logic [LANES*LANE_W-1:0] in_vec_a,
    input logic [RES_W-1:0]        in_acc,
    input logic                    out_valid,
    input logic [RES_W-1:0]        out_result
);

    logic [1:0] warm_cnt;
    logic       warm;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt <= 2'd0;
        end else if (warm_cnt != 2'd2) begin
            warm_cnt <= warm_cnt + 2'd1;
        end
    end

    assign warm = (warm_cnt == 2'd2);

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !out_valid) |-> $stable(out_result));

    // R11
    zero_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_vec_a == '0, 2)) |-> (out_result == $past(in_acc, 2)));

    // R6
    uns_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_mode == 2'b10, 2) && $past(in_acc == '1, 2))
        |-> (out_result == '1));

endmodule

bind dotacc_sat dotacc_sat_chk #(.LANES(LANES), .LANE_W(LANE_W), .RES_W(RES_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_vec_a   (in_vec_a),
    .in_acc     (in_acc),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/dotacc_sat_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps corner lane values, accumulators, modes and the packed flag on a
// two-lane, 16-bit-lane, 40-bit-result configuration against an arithmetic model.
module dotacc_sat_tb_top;

    localparam int LN  = 2;
    localparam int LW  = 16;
    localparam int RW  = 40;
    localparam int OPW = LN * LW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [1:0]     in_mode = 2'b00;
    logic           in_packed = 1'b0;
    logic [OPW-1:0] in_vec_a = '0;
    logic [OPW-1:0] in_vec_b = '0;
    logic [RW-1:0]  in_acc = '0;
    logic           out_valid;
    logic [RW-1:0]  out_result;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    dotacc_sat #(.LANES(LN), .LANE_W(LW), .RES_W(RW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_mode    (in_mode),
        .in_packed  (in_packed),
        .in_vec_a   (in_vec_a),
        .in_vec_b   (in_vec_b),
        .in_acc     (in_acc),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    logic [15:0] corner [8];
    logic [RW-1:0] accs [8];
    string exp_tag;

    // Reference: widen each lane per mode, sum in 64 bits, then clamp the final add.
    function automatic logic [RW-1:0] model(input logic [1:0] m, input logic pk,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [RW-1:0] acc, output string tag);
        int     n = pk ? 4 : LN;
        int     w = pk ? 8 : LW;
        longint sum = 0;
        longint t;
        longint maxu = (longint'(1) << RW) - 1;
        longint maxs = (longint'(1) << (RW - 1)) - 1;
        longint mins = -(longint'(1) << (RW - 1));
        logic [RW-1:0] r;
        for (int k = 0; k < n; k++) begin
            longint ua = longint'((a >> (k * w))) & ((longint'(1) << w) - 1);
            longint ub = longint'((b >> (k * w))) & ((longint'(1) << w) - 1);
            longint sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
            longint sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
            longint ea = (m == 2'b10) ? ua : sa;
            longint eb = (m == 2'b00 || m == 2'b11) ? sb : ub;
            sum += ea * eb;
        end
        if (m == 2'b10) begin
            t = longint'({24'd0, acc}) + sum;
            r = (t > maxu) ? {RW{1'b1}} : t[RW-1:0];
            tag = (t > maxu) ? "R6" : "R3";
        end else begin
            t = longint'({{24{acc[RW-1]}}, acc}) + sum;
            if (t > maxs) r = maxs[RW-1:0];
            else if (t < mins) r = mins[RW-1:0];
            else r = t[RW-1:0];
            if (t > maxs || t < mins) tag = "R5";
            else if (m == 2'b01) tag = "R2";
            else if (m == 2'b11) tag = "R4";
            else tag = "R1";
        end
        if (pk) tag = {tag, "/R7"};
        return r;
    endfunction

    task automatic check(input string tag, input logic [RW-1:0] got, input logic [RW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Issue one operation and check latency, result and hold at the negedges that follow.
    task automatic run_op(input logic [1:0] m, input logic pk, input logic [31:0] a,
                          input logic [31:0] b, input logic [RW-1:0] acc, input bit deep);
        logic [RW-1:0] exp;
        string tag;
        exp = model(m, pk, a, b, acc, tag);
        @(negedge clk);
        in_mode = m; in_packed = pk; in_vec_a = a; in_vec_b = b; in_acc = acc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (deep) check("R8 early", {39'd0, out_valid}, '0);
        @(negedge clk);
        check("R8 valid", {39'd0, out_valid}, 40'd1);
        check(tag, out_result, exp);
        if (deep) begin
            in_acc = ~acc; in_vec_a = ~a;
            @(negedge clk);
            check("R9 valid", {39'd0, out_valid}, '0);
            check("R9 hold", out_result, exp);
        end
    endtask

    initial begin
        corner = '{16'h0000, 16'h0001, 16'h0002, 16'h7fff, 16'h8000, 16'h8001, 16'hfffe, 16'hffff};
        accs = '{40'h00_0000_0000, 40'h00_0000_0001, 40'hff_ffff_ffff, 40'h7f_ffff_ffff,
                 40'h80_0000_0000, 40'hff_ffff_fff0, 40'h7f_ffff_fff0, 40'h80_0000_0010};
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 valid", {39'd0, out_valid}, '0);
        check("R10 result", out_result, '0);
        rst_n = 1'b1;

        // R11: zero vector A passes the accumulator through in every mode.
        for (int m = 0; m < 4; m++) begin
            run_op(2'(m), 1'b0, 32'h0, 32'h8000ffff, 40'h80_0000_0000, 1'b1);
            run_op(2'(m), 1'b1, 32'h0, 32'hff80ff7f, 40'h7f_ffff_ffff, 1'b0);
        end

        // Sweep of modes (R1..R4), packing (R7) and saturation bounds (R5, R6).
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        for (int k = 0; k < 8; k++) begin
                            run_op(2'(m), p[0], {corner[i], corner[(i + 5) & 7]},
                                   {corner[j], corner[(j + 3) & 7]}, accs[k], (k == 0));
                        end
                    end
                end
            end
        end

        // R10: a reset in mid-stream clears the outputs.
        @(negedge clk);
        in_vec_a = 32'h7fff7fff; in_vec_b = 32'h7fff7fff; in_acc = 40'h12; in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R10 mid valid", {39'd0, out_valid}, '0);
        check("R10 mid result", out_result, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule